// File: doc/BRIEF.md
# Single-Cell Charge Sequencer

This block is the control core of a charger for one nickel-based cell. It decides which charge phase is active. Those phases are power-up hold, waiting for a cell, a gentle precharge of a deeply drained cell, full-rate fast charge with periodic cell tests, a timed top-off, indefinite trickle maintenance, a latched fault and an externally commanded suspend. Analog sensing is outside it. The block sees only digital comparator flags for cell voltage, thermistor temperature, undervoltage of the supply and a floating timer pin. It also sees a one-second tick and the verdicts of a separate end-of-charge detector.

The outputs describe the phase to the rest of the charger. A two-bit duty mode selects the pulse ratio the current regulator applies. A charge-enable bit tells whether current may flow at all. A two-bit status mode drives an indicator. A one-cycle start pulse launches the detector's cell test. The fast-charge safety timeout is an input value in seconds, so software or straps may choose anything from half an hour to five hours. Top-off always lasts half of that value. Over-voltage is judged against the loaded limit while current is enabled, and against the lower open-circuit limit while it is not.

Top module: `chg_seq_top`

## Requirements
- R1: While `uvlo` is high the sequencer holds its power-up state with `duty_mode`=0, `status_mode`=0 and `chg_en`=0. All phase timers restart from zero when it is released.
- R2: `timer_float` high forces the suspend state (duty 0, status 0) from any state on the next clock. Once it is released, the sequencer re-enters the wait-for-cell state.
- R3: In the wait-for-cell state the sequencer advances to precharge only in a cycle where `over_open`, `temp_cold` and `temp_warm` are all low. Otherwise it stays with duty 0 and status 0.
- R4: Precharge drives `duty_mode`=2 (quarter) and `status_mode`=2 (slow blink). It moves to fast charge on the first clock where `cell_low` is low.
- R5: Precharge moves to fault if `PRE_SECS` ticks have elapsed in it, if `temp_hot` is high, or if the active voltage limit is exceeded.
- R6: Fast charge drives `duty_mode`=1 (full) and `status_mode`=1 (high). After every `TEST_SECS` ticks spent in fast charge, `det_start` pulses for one cycle and a cell test state follows with duty 0 and status 1. In that state a `det_ack` with `det_bad` leads to fault, one with `det_term` leads to top-off, and one with neither returns to fast charge.
- R7: The safety timer counts ticks across fast charge and its cell tests. When it reaches `fast_limit_s` the sequencer enters top-off with the timer restarted.
- R8: Top-off drives `duty_mode`=2 and `status_mode`=1. After floor(`fast_limit_s`/2) ticks it enters maintenance, which drives `duty_mode`=3 (trickle) and `status_mode`=0.
- R9: `temp_hot` during fast charge, cell test or top-off leads to maintenance, not fault.
- R10: The voltage limit applied is `over_loaded` while `chg_en` is high and `over_open` while it is low, i.e. during the cell test. Exceeding it in precharge, fast charge, cell test or top-off leads to fault.
- R11: Fault drives `duty_mode`=0 and `status_mode`=3 (fast blink). It is left for the wait-for-cell state only when `over_loaded` is high.
- R12: Maintenance is left for the wait-for-cell state when `over_open` is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Supply below undervoltage threshold |
| timer_float | input | 1 | Timer pin left floating (suspend request) |
| cell_low | input | 1 | Cell voltage below the precharge exit level |
| over_loaded | input | 1 | Cell above the limit used while current flows |
| over_open | input | 1 | Cell above the open-circuit limit |
| temp_cold | input | 1 | Thermistor below the cold start limit |
| temp_warm | input | 1 | Thermistor above the hot no-start limit |
| temp_hot | input | 1 | Thermistor above the hot stop limit |
| tick_1hz | input | 1 | One-cycle pulse per second |
| det_ack | input | 1 | Detector finished its cell test |
| det_term | input | 1 | Detector verdict: charge complete |
| det_bad | input | 1 | Detector verdict: cell impedance too high |
| fast_limit_s | input | TO_W | Fast-charge safety timeout in seconds |
| duty_mode | output | 2 | 0 off, 1 full, 2 quarter, 3 trickle |
| chg_en | output | 1 | Charge current permitted |
| status_mode | output | 2 | 0 low, 1 high, 2 slow blink, 3 fast blink |
| det_start | output | 1 | One-cycle pulse launching a cell test |

## Verification
The bench goes after the timer edges. It checks one tick short of the precharge limit and exactly at it, an odd safety timeout whose half rounds down, and a timeout of one tick. An off-by-one counter or a ceiling in place of a floor shows up there as a phase that ends one tick early or late. It checks that a high `over_open` is harmless in fast charge but fatal once the cell test drops the enable. A design that picks the wrong limit would fault mid-charge or miss an open cell. It also shows that hot stop in fast charge lands in maintenance while in precharge it lands in fault, and that an undervoltage in mid-precharge gives a full fresh timeout. A sequencer that kept stale timer counts would fault early.

// File: rtl/chg_pkg.sv
package chg_pkg;

  localparam int NST = 9;

  localparam int S_POR   = 0;
  localparam int S_PRES  = 1;
  localparam int S_PRE   = 2;
  localparam int S_FAST  = 3;
  localparam int S_TEST  = 4;
  localparam int S_TOP   = 5;
  localparam int S_MAINT = 6;
  localparam int S_FAULT = 7;
  localparam int S_SUSP  = 8;

  typedef logic [NST-1:0] st_vec_t;

  typedef enum logic [1:0] {
    DUTY_OFF     = 2'd0,
    DUTY_FULL    = 2'd1,
    DUTY_QTR     = 2'd2,
    DUTY_TRICKLE = 2'd3
  } duty_e;

  typedef enum logic [1:0] {
    STS_LOW  = 2'd0,
    STS_HIGH = 2'd1,
    STS_SLOW = 2'd2,
    STS_FAST = 2'd3
  } status_e;

  function automatic st_vec_t st_bit(input int unsigned idx);
    st_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/chg_sec_cnt.sv
module chg_sec_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/chg_next_state.sv
module chg_next_state
  import chg_pkg::*;
(
  input  st_vec_t st_q,
  input  logic    uvlo,
  input  logic    timer_float,
  input  logic    cell_low,
  input  logic    over_loaded,
  input  logic    over_open,
  input  logic    over_max,
  input  logic    temp_cold,
  input  logic    temp_warm,
  input  logic    temp_hot,
  input  logic    det_ack,
  input  logic    det_term,
  input  logic    det_bad,
  input  logic    pre_expire,
  input  logic    fast_expire,
  input  logic    top_expire,
  input  logic    test_due,
  output st_vec_t st_d
);

  logic start_ok;
  assign start_ok = !over_open && !temp_cold && !temp_warm;

  always_comb begin
    st_d = st_q;
    if (uvlo) begin
      st_d = st_bit(S_POR);
    end else if (timer_float) begin
      st_d = st_bit(S_SUSP);
    end else if (!$onehot(st_q)) begin
      st_d = st_bit(S_POR);
    end else if (st_q[S_POR]) begin
      st_d = st_bit(S_PRES);
    end else if (st_q[S_PRES]) begin
      if (start_ok) st_d = st_bit(S_PRE);
    end else if (st_q[S_PRE]) begin
      if (over_max || temp_hot || pre_expire) st_d = st_bit(S_FAULT);
      else if (!cell_low)                     st_d = st_bit(S_FAST);
    end else if (st_q[S_FAST]) begin
      if (over_max)         st_d = st_bit(S_FAULT);
      else if (temp_hot)    st_d = st_bit(S_MAINT);
      else if (fast_expire) st_d = st_bit(S_TOP);
      else if (test_due)    st_d = st_bit(S_TEST);
    end else if (st_q[S_TEST]) begin
      if (over_max)      st_d = st_bit(S_FAULT);
      else if (temp_hot) st_d = st_bit(S_MAINT);
      else if (det_ack) begin
        if (det_bad)       st_d = st_bit(S_FAULT);
        else if (det_term) st_d = st_bit(S_TOP);
        else               st_d = st_bit(S_FAST);
      end else if (fast_expire) begin
        st_d = st_bit(S_TOP);
      end
    end else if (st_q[S_TOP]) begin
      if (over_max)                    st_d = st_bit(S_FAULT);
      else if (temp_hot || top_expire) st_d = st_bit(S_MAINT);
    end else if (st_q[S_MAINT]) begin
      if (over_open) st_d = st_bit(S_PRES);
    end else if (st_q[S_FAULT]) begin
      if (over_loaded) st_d = st_bit(S_PRES);
    end else begin
      st_d = st_bit(S_PRES);
    end
  end

endmodule

// File: rtl/chg_out_decode.sv
module chg_out_decode
  import chg_pkg::*;
(
  input  st_vec_t st_q,
  output duty_e   duty,
  output status_e sts
);

  always_comb begin
    duty = DUTY_OFF;
    sts  = STS_LOW;
    if (st_q[S_PRE]) begin
      duty = DUTY_QTR;
      sts  = STS_SLOW;
    end
    if (st_q[S_FAST]) begin
      duty = DUTY_FULL;
      sts  = STS_HIGH;
    end
    if (st_q[S_TEST]) begin
      sts  = STS_HIGH;
    end
    if (st_q[S_TOP]) begin
      duty = DUTY_QTR;
      sts  = STS_HIGH;
    end
    if (st_q[S_MAINT]) begin
      duty = DUTY_TRICKLE;
    end
    if (st_q[S_FAULT]) begin
      sts  = STS_FAST;
    end
  end

endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_pkg::*;
#(
  parameter int TO_W      = 15,
  parameter int PRE_SECS  = 1800,
  parameter int TEST_SECS = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uvlo,
  input  logic            timer_float,
  input  logic            cell_low,
  input  logic            over_loaded,
  input  logic            over_open,
  input  logic            temp_cold,
  input  logic            temp_warm,
  input  logic            temp_hot,
  input  logic            tick_1hz,
  input  logic            det_ack,
  input  logic            det_term,
  input  logic            det_bad,
  input  logic [TO_W-1:0] fast_limit_s,
  output logic [1:0]      duty_mode,
  output logic            chg_en,
  output logic [1:0]      status_mode,
  output logic            det_start
);

  localparam int PRE_W = $clog2(PRE_SECS + 1);
  localparam int CNT_W = (TO_W > PRE_W) ? TO_W : PRE_W;
  localparam int IV_W  = $clog2(TEST_SECS + 1);

  function automatic logic [CNT_W-1:0] fast_len(input logic [TO_W-1:0] t);
    return CNT_W'(t);
  endfunction

  function automatic logic [CNT_W-1:0] topoff_len(input logic [TO_W-1:0] t);
    return CNT_W'(t >> 1);
  endfunction

  st_vec_t st_q;
  st_vec_t st_d;

  duty_e   duty;
  status_e sts;

  logic [CNT_W-1:0] phase_cnt;
  logic [IV_W-1:0]  ival_cnt;

  logic over_max;
  logic pre_expire;
  logic fast_expire;
  logic top_expire;
  logic test_due;
  logic keep_safety;
  logic phase_clr;
  logic ival_clr;
  logic in_fast_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= st_bit(S_POR);
    else        st_q <= st_d;
  end

  chg_out_decode u_dec (
    .st_q (st_q),
    .duty (duty),
    .sts  (sts)
  );

  assign duty_mode   = duty;
  assign status_mode = sts;
  assign chg_en      = (duty != DUTY_OFF);

  assign over_max = chg_en ? over_loaded : over_open;

  assign in_fast_run = st_q[S_FAST] | st_q[S_TEST];
  assign keep_safety = (st_q[S_FAST] && st_d[S_TEST]) ||
                       (st_q[S_TEST] && st_d[S_FAST]);
  assign phase_clr   = ((st_d != st_q) && !keep_safety) || st_q[S_POR];
  assign ival_clr    = !st_q[S_FAST];

  chg_sec_cnt #(.W(CNT_W)) u_phase_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (phase_clr),
    .tick  (tick_1hz),
    .cnt   (phase_cnt)
  );

  chg_sec_cnt #(.W(IV_W)) u_ival_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ival_clr),
    .tick  (tick_1hz),
    .cnt   (ival_cnt)
  );

  assign pre_expire  = st_q[S_PRE] && (phase_cnt >= CNT_W'(PRE_SECS));
  assign fast_expire = in_fast_run && (phase_cnt >= fast_len(fast_limit_s));
  assign top_expire  = st_q[S_TOP] && (phase_cnt >= topoff_len(fast_limit_s));
  assign test_due    = st_q[S_FAST] && (ival_cnt >= IV_W'(TEST_SECS));

  chg_next_state u_ns (
    .st_q        (st_q),
    .uvlo        (uvlo),
    .timer_float (timer_float),
    .cell_low    (cell_low),
    .over_loaded (over_loaded),
    .over_open   (over_open),
    .over_max    (over_max),
    .temp_cold   (temp_cold),
    .temp_warm   (temp_warm),
    .temp_hot    (temp_hot),
    .det_ack     (det_ack),
    .det_term    (det_term),
    .det_bad     (det_bad),
    .pre_expire  (pre_expire),
    .fast_expire (fast_expire),
    .top_expire  (top_expire),
    .test_due    (test_due),
    .st_d        (st_d)
  );

  assign det_start = st_q[S_FAST] && st_d[S_TEST];

endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk
  import chg_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    uvlo,
  input logic    timer_float,
  input logic    over_loaded,
  input logic    over_open,
  input logic    temp_cold,
  input logic    temp_warm,
  input logic    temp_hot,
  input logic    det_start,
  input logic    chg_en,
  input st_vec_t st_q
);

  logic quiet;
  assign quiet = !uvlo && !timer_float;

  assert_uvlo_por_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (st_q == st_bit(S_POR)) && !chg_en);

  assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(st_q));

  assert_float_suspend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet == 1'b0 && !uvlo && timer_float |=> st_q[S_SUSP] && !chg_en);

  assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && st_q[S_PRES] && (temp_cold || temp_warm || over_open) |=> st_q[S_PRES]);

  assert_start_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    det_start |=> st_q[S_TEST] && !chg_en);

  assert_hot_maint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (st_q[S_FAST] || st_q[S_TOP]) && !over_loaded && temp_hot
    |=> st_q[S_MAINT]);

  assert_overmax_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (st_q[S_PRE] || st_q[S_FAST] || st_q[S_TOP]) && over_loaded
    |=> st_q[S_FAULT]);

  assert_open_in_test_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && st_q[S_TEST] && over_open |=> st_q[S_FAULT]);

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && st_q[S_FAULT] && !over_loaded |=> st_q[S_FAULT]);

endmodule

bind chg_seq_top chg_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .uvlo        (uvlo),
  .timer_float (timer_float),
  .over_loaded (over_loaded),
  .over_open   (over_open),
  .temp_cold   (temp_cold),
  .temp_warm   (temp_warm),
  .temp_hot    (temp_hot),
  .det_start   (det_start),
  .chg_en      (chg_en),
  .st_q        (st_q)
);

// File: tb/chg_seq_top_test.sv
module chg_seq_top_test;

  localparam int TO_W   = 15;
  localparam int PRE_T  = 40;
  localparam int TEST_T = 6;

  typedef enum int {P_OFF, P_PRE, P_FAST, P_TEST, P_TOP, P_MAINT, P_FAULT} ph_e;

  logic clk = 1'b0;
  logic rst_n;
  logic uvlo, timer_float, cell_low, over_loaded, over_open;
  logic temp_cold, temp_warm, temp_hot, tick_1hz;
  logic det_ack, det_term, det_bad;
  logic [TO_W-1:0] fast_limit_s;
  logic [1:0] duty_mode, status_mode;
  logic chg_en, det_start;

  logic [1:0] ack_p;
  int checks = 0;
  int fails = 0;
  int starts = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  chg_seq_top #(.TO_W(TO_W), .PRE_SECS(PRE_T), .TEST_SECS(TEST_T)) uut (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .timer_float(timer_float),
    .cell_low(cell_low), .over_loaded(over_loaded), .over_open(over_open),
    .temp_cold(temp_cold), .temp_warm(temp_warm), .temp_hot(temp_hot),
    .tick_1hz(tick_1hz), .det_ack(det_ack), .det_term(det_term),
    .det_bad(det_bad), .fast_limit_s(fast_limit_s), .duty_mode(duty_mode),
    .chg_en(chg_en), .status_mode(status_mode), .det_start(det_start)
  );

  // detector model: answers two cycles after a start pulse
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_p <= 2'b00;
    else        ack_p <= {ack_p[0], det_start};
  end
  assign det_ack = ack_p[1];

  always @(posedge clk) if (rst_n && det_start) starts++;

  function automatic logic [1:0] exp_duty(ph_e p);
    case (p)
      P_PRE, P_TOP: return 2'd2;
      P_FAST:       return 2'd1;
      P_MAINT:      return 2'd3;
      default:      return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] exp_sts(ph_e p);
    case (p)
      P_PRE:                return 2'd2;
      P_FAST, P_TEST, P_TOP: return 2'd1;
      P_FAULT:              return 2'd3;
      default:              return 2'd0;
    endcase
  endfunction

  function automatic int exp_topoff_ticks(int t);
    return t / 2;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(int n);
    repeat (n) begin
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic check_val(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic expect_ph(string req, ph_e p);
    int got, want;
    got  = {chg_en, duty_mode, status_mode};
    want = {(exp_duty(p) != 2'd0), exp_duty(p), exp_sts(p)};
    check_val(req, got, want);
  endtask

  task automatic to_pre();
    uvlo = 1'b1; timer_float = 1'b0; cell_low = 1'b1;
    over_loaded = 1'b0; over_open = 1'b0;
    temp_cold = 1'b0; temp_warm = 1'b0; temp_hot = 1'b0;
    det_term = 1'b0; det_bad = 1'b0;
    cyc(2);
    uvlo = 1'b0;
    cyc(3);
  endtask

  task automatic to_fast();
    to_pre();
    cell_low = 1'b0;
    cyc(1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int k, t, lim;
    void'($urandom(32'd2718));
    rst_n = 1'b0; uvlo = 1'b1; timer_float = 1'b0; cell_low = 1'b1;
    over_loaded = 1'b0; over_open = 1'b0; temp_cold = 1'b0;
    temp_warm = 1'b0; temp_hot = 1'b0; tick_1hz = 1'b0;
    det_term = 1'b0; det_bad = 1'b0; fast_limit_s = TO_W'(1000);
    cyc(3);
    expect_ph("R1 reset", P_OFF);
    rst_n = 1'b1;
    tk(5);
    expect_ph("R1 held by uvlo", P_OFF);

    // R3 start qualification
    uvlo = 1'b0; temp_cold = 1'b1;
    cyc(4); expect_ph("R3 cold blocks start", P_OFF);
    temp_cold = 1'b0; temp_warm = 1'b1;
    cyc(4); expect_ph("R3 warm blocks start", P_OFF);
    temp_warm = 1'b0; over_open = 1'b1;
    cyc(4); expect_ph("R3 open cell blocks start", P_OFF);
    over_open = 1'b0;
    cyc(1); expect_ph("R3 R4 start into precharge", P_PRE);

    // R1 timers restart after uvlo; R5 precharge timeout edge
    tk(30);
    uvlo = 1'b1; cyc(1);
    expect_ph("R1 uvlo mid precharge", P_OFF);
    uvlo = 1'b0; cyc(2);
    expect_ph("R1 back in precharge", P_PRE);
    tk(PRE_T - 1);
    expect_ph("R1 R5 one tick before timeout", P_PRE);
    tk(1);
    expect_ph("R5 precharge timeout to fault", P_FAULT);

    // R11 fault exit
    over_open = 1'b1; cyc(3);
    expect_ph("R11 open limit does not clear fault", P_FAULT);
    over_loaded = 1'b1; cyc(1);
    expect_ph("R11 removal leaves fault", P_OFF);
    cyc(2);
    expect_ph("R3 still waiting while open", P_OFF);

    // R5 hot and over-limit in precharge; R10 loaded limit applies
    to_pre();
    over_open = 1'b1; cyc(3);
    expect_ph("R10 open flag ignored while enabled", P_PRE);
    over_open = 1'b0; temp_hot = 1'b1; cyc(1);
    expect_ph("R5 hot stop in precharge", P_FAULT);
    to_pre();
    over_loaded = 1'b1; cyc(1);
    expect_ph("R5 R10 loaded limit in precharge", P_FAULT);

    // R4 R6 fast charge and cell test cadence
    to_fast();
    expect_ph("R4 R6 fast charge entered", P_FAST);
    k = starts;
    tk(TEST_T - 1);
    expect_ph("R6 no test before interval", P_FAST);
    check_val("R6 no start pulse yet", starts - k, 0);
    tk(1);
    expect_ph("R6 cell test state", P_TEST);
    check_val("R6 one start pulse", starts - k, 1);
    cyc(3);
    expect_ph("R6 pass returns to fast", P_FAST);

    // R10 open limit during cell test
    over_open = 1'b1;
    tk(TEST_T - 1);
    expect_ph("R10 open flag ignored in fast", P_FAST);
    tk(1); cyc(1);
    expect_ph("R10 open limit in cell test", P_FAULT);

    // R6 verdicts
    to_fast();
    det_bad = 1'b1; tk(TEST_T); cyc(3);
    expect_ph("R6 bad verdict to fault", P_FAULT);
    to_fast();
    det_term = 1'b1; tk(TEST_T); cyc(3);
    expect_ph("R6 R8 done verdict to top-off", P_TOP);
    det_term = 1'b0;

    // R9 hot in top-off and fast
    temp_hot = 1'b1; cyc(1);
    expect_ph("R9 hot in top-off to maintenance", P_MAINT);
    temp_hot = 1'b0;
    cell_low = 1'b1; cyc(3);
    expect_ph("R12 maintenance holds", P_MAINT);
    over_open = 1'b1; cyc(1);
    expect_ph("R12 open limit leaves maintenance", P_OFF);
    to_fast();
    temp_hot = 1'b1; cyc(1);
    expect_ph("R9 hot in fast to maintenance", P_MAINT);

    // R2 suspend
    to_fast();
    timer_float = 1'b1; cyc(1);
    expect_ph("R2 suspend from fast", P_OFF);
    tk(20);
    expect_ph("R2 suspend holds", P_OFF);
    cell_low = 1'b1; timer_float = 1'b0; cyc(2);
    expect_ph("R2 release to precharge", P_PRE);
    temp_hot = 1'b1; cyc(1); temp_hot = 1'b0;
    timer_float = 1'b1; cyc(1);
    expect_ph("R2 suspend from fault", P_OFF);
    timer_float = 1'b0; cyc(2);
    expect_ph("R2 fault cleared by suspend", P_PRE);

    // R7 safety timeout, directed edges then random
    for (int i = 0; i < 8; i++) begin
      t = (i == 0) ? 1 : (i == 1) ? TEST_T : 1 + int'($urandom_range(29));
      fast_limit_s = TO_W'(t);
      to_fast();
      k = 0;
      for (int j = 0; j < 200; j++) begin
        if (duty_mode == 2'd2) break;
        if (duty_mode == 2'd0) cyc(1);
        else begin tk(1); k++; end
      end
      check_val("R7 safety timeout ticks", k, t);
    end

    // R8 top-off length = half the timeout, rounded down
    for (int i = 0; i < 8; i++) begin
      t = (i == 0) ? 25 : (i == 1) ? 1 : int'($urandom_range(40));
      if (t == 0) t = 2;
      fast_limit_s = TO_W'(t);
      det_term = 1'b1;
      to_fast();
      det_term = 1'b1;
      for (int j = 0; j < 200; j++) begin
        if (duty_mode == 2'd2) break;
        if (duty_mode == 2'd0) cyc(1);
        else tk(1);
      end
      cyc(1);
      k = 0;
      lim = 0;
      while (duty_mode == 2'd2 && lim < 200) begin
        tk(1); k++; lim++;
      end
      check_val("R8 top-off ticks", k, exp_topoff_ticks(t));
      expect_ph("R8 maintenance after top-off", P_MAINT);
    end
    det_term = 1'b0;

    finish_run();
  end

endmodule